// File: doc/BRIEF.md
# Interrupt Coalescing Timer Unit

This block collects ten event sources of a 10/100 Mbps network controller into a sticky status register, qualifies them with a mask, and drives a single interrupt line. Two completion groups, one for receive and one for transmit, do not go straight into status. Each group has its own coalescing lane that holds completions back until a programmed number of event cycles has been seen, or until a timeout expires, whichever comes first. The held bits are then released into status together.

The timeout is counted in base cycles. A base cycle is a fixed stretch of system clocks whose length depends on the link speed input and on a long-cycle select bit in each lane's settings. The parameter `BASE_CLKS` gives the number of clocks in the shortest base cycle (normal length at 100 Mbps). At 100 MHz this is 512 clocks (5.12 us). A simulation can set it small so that the cycles shrink in proportion. Software writes a status clear, a mask and a control word through a small register port, and it reads any of them back combinationally.

Top module: `irq_coalesce_unit`

## Requirements
- R1: After reset, the status, mask and control registers read as zero and `irq_o` is low.
- R2: Register addresses are as follows. Address 0 holds status (bits 9:0). Address 1 holds mask (bits 9:0). Address 2 holds control (bits 15:0). Address 3 reads as zero. Mask and control read back the value written, and unused read bits are zero.
- R3: Writing to address 0 clears every status bit whose write-data bit is 1 and leaves the others unchanged. A status bit is cleared only by such a write. If an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R4: Source bits 1, 3, 5, 7, 8 and 9 are not coalesced. A one-cycle pulse on any of them sets its status bit in the clock edge that samples the pulse, whatever the control settings are.
- R5: `irq_o` is high exactly when some status bit is 1 and its mask bit is 1. The mask never changes status.
- R6: Control bits 7:0 configure the receive lane and bits 15:8 configure the transmit lane. In each byte, bit 7 is the long-cycle select, bits 6:4 are the event threshold and bits 3:0 are the timeout in base cycles. A threshold of 0 acts as 1. With threshold 0 or 1 and timeout 0, a completion sets status in the same edge as a bypass event.
- R7: With threshold n, the edge that samples the n-th event cycle of a lane releases all of that lane's held bits into status. A cycle in which several of the lane's bits pulse counts as one event. After a release, the count starts again from zero.
- R8: With timeout T > 0, the lane's timer starts at the edge that samples the first held event. It releases the held bits T base cycles later, that is T x cycle-length clock edges after that first edge. Later events do not restart the timer.
- R9: The base cycle length in clocks is BASE_CLKS at 100 Mbps with a normal cycle, 10 x BASE_CLKS at 10 Mbps with a normal cycle, 16 x BASE_CLKS at 100 Mbps with a long cycle, and 160 x BASE_CLKS at 10 Mbps with a long cycle. `speed100_i` = 1 selects 100 Mbps.
- R10: The receive lane holds source bits 0 and 6 and the transmit lane holds bits 2 and 4. Each lane uses only its own settings, and events of one lane never advance or release the other lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | N_SRC | One-cycle event pulses, one per source bit |
| speed100_i | input | 1 | Link speed: 1 = 100 Mbps, 0 = 10 Mbps |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | DATA_W | Combinational read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets the exact release edge in several cases: count-based release, timeout release with a second event arriving while the timer runs, and each of the four cycle lengths. A lane with an off-by-one counter or timer would release one clock early or late and miss the pre-release zero check or the release check. It also tests a cycle carrying two events of a lane, which a design that counts bits instead of cycles would release early. It also covers a clear that collides with a set in the same cycle, which a design giving priority to the clear would lose, and a transmit completion held while receive completions pass, which exposes lanes that share state. Mask changes are checked against a status that must stay put, which catches a design that gates status instead of the interrupt.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;

   localparam int unsigned NSRC = 10;
   localparam int unsigned LANES = 2;

   // Lane groups (R10): receive holds bits 0,6; transmit holds bits 2,4
   localparam logic [NSRC-1:0] RX_GRP = 10'h041;
   localparam logic [NSRC-1:0] TX_GRP = 10'h014;
   localparam logic [NSRC-1:0] COAL_ALL = RX_GRP | TX_GRP;

   typedef enum logic [1:0] {
      ADDR_STAT = 2'd0,
      ADDR_MASK = 2'd1,
      ADDR_CTRL = 2'd2,
      ADDR_NONE = 2'd3
   } reg_addr_e;

   // One byte of the control register per lane (R6)
   typedef struct packed {
      logic       long_cyc;
      logic [2:0] thr;
      logic [3:0] tmo;
   } lane_cfg_t;

endpackage

// File: rtl/coal_cycle_sel.sv
module coal_cycle_sel #(
   parameter int unsigned BASE_CLKS = 512,
   localparam int unsigned CW = $clog2(BASE_CLKS * 160 + 1)
) (
   input  logic          speed100_i,
   input  logic          long_i,
   output logic [CW-1:0] len_o
);

   localparam logic [CW-1:0] LEN_FAST_NORM = CW'(BASE_CLKS);
   localparam logic [CW-1:0] LEN_SLOW_NORM = CW'(BASE_CLKS * 10);
   localparam logic [CW-1:0] LEN_FAST_LONG = CW'(BASE_CLKS * 16);
   localparam logic [CW-1:0] LEN_SLOW_LONG = CW'(BASE_CLKS * 160);

   always_comb begin
      unique case ({speed100_i, long_i})
         2'b10:   len_o = LEN_FAST_NORM;
         2'b11:   len_o = LEN_FAST_LONG;
         2'b00:   len_o = LEN_SLOW_NORM;
         default: len_o = LEN_SLOW_LONG;
      endcase
   end

endmodule

// File: rtl/coal_lane.sv
module coal_lane
   import irq_coal_pkg::*;
#(
   parameter int unsigned N_SRC     = 10,
   parameter int unsigned BASE_CLKS = 512,
   localparam int unsigned CW = $clog2(BASE_CLKS * 160 + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] evt_i,
   input  logic             speed100_i,
   input  lane_cfg_t        cfg_i,
   output logic [N_SRC-1:0] rel_o
);

   logic [N_SRC-1:0] held_q;
   logic [2:0]       cnt_q;
   logic             act_q;
   logic [CW-1:0]    sub_q;
   logic [3:0]       units_q;
   logic [CW-1:0]    cyc_len;

   logic       any_evt, hit_cnt, tick, expire, release_now;
   logic [3:0] thr_eff;

   coal_cycle_sel #(.BASE_CLKS(BASE_CLKS)) u_cyc (
      .speed100_i (speed100_i),
      .long_i     (cfg_i.long_cyc),
      .len_o      (cyc_len)
   );

   always_comb begin
      any_evt     = |evt_i;
      thr_eff     = (cfg_i.thr == 3'd0) ? 4'd1 : {1'b0, cfg_i.thr};
      hit_cnt     = any_evt && (({1'b0, cnt_q} + 4'd1) >= thr_eff);
      tick        = act_q && (sub_q >= (cyc_len - CW'(1)));
      expire      = act_q && ((cfg_i.tmo == 4'd0) ||
                              (tick && (units_q == (cfg_i.tmo - 4'd1))));
      release_now = hit_cnt || expire;
      rel_o       = release_now ? (held_q | evt_i) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q  <= '0;
         cnt_q   <= '0;
         act_q   <= 1'b0;
         sub_q   <= '0;
         units_q <= '0;
      end else if (release_now) begin
         held_q  <= '0;
         cnt_q   <= '0;
         act_q   <= 1'b0;
         sub_q   <= '0;
         units_q <= '0;
      end else begin
         held_q <= held_q | evt_i;
         if (any_evt) cnt_q <= cnt_q + 3'd1;
         if (!act_q) begin
            if (any_evt && (cfg_i.tmo != 4'd0)) begin
               act_q   <= 1'b1;
               sub_q   <= '0;
               units_q <= '0;
            end
         end else if (tick) begin
            sub_q   <= '0;
            units_q <= units_q + 4'd1;
         end else begin
            sub_q <= sub_q + CW'(1);
         end
      end
   end

endmodule

// File: rtl/irq_coalesce_unit.sv
module irq_coalesce_unit
   import irq_coal_pkg::*;
#(
   parameter int unsigned N_SRC     = 10,
   parameter int unsigned BASE_CLKS = 512,
   parameter int unsigned DATA_W    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  evt_i,
   input  logic              speed100_i,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [1:0]        rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              irq_o
);

   localparam int unsigned CTRL_W = 8 * LANES;
   localparam logic [LANES-1:0][N_SRC-1:0] LANE_GRP = {TX_GRP, RX_GRP};

   if (N_SRC != NSRC) begin : g_bad_nsrc
      $error("irq_coalesce_unit: N_SRC must equal %0d", NSRC);
   end
   if (BASE_CLKS < 1) begin : g_bad_base
      $error("irq_coalesce_unit: BASE_CLKS must be at least 1");
   end
   if (DATA_W < CTRL_W) begin : g_bad_dw
      $error("irq_coalesce_unit: DATA_W must hold the control word");
   end

   logic [N_SRC-1:0]             stat_q, mask_q;
   logic [CTRL_W-1:0]            ctrl_q;
   logic [LANES-1:0][N_SRC-1:0]  rel_v;
   logic [N_SRC-1:0]             rel_all, set_vec, clr_vec;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      coal_lane #(.N_SRC(N_SRC), .BASE_CLKS(BASE_CLKS)) u_lane (
         .clk        (clk),
         .rst_n      (rst_n),
         .evt_i      (evt_i & LANE_GRP[g]),
         .speed100_i (speed100_i),
         .cfg_i      (lane_cfg_t'(ctrl_q[8*g +: 8])),
         .rel_o      (rel_v[g])
      );
   end

   always_comb begin
      rel_all = '0;
      for (int l = 0; l < LANES; l++) rel_all = rel_all | rel_v[l];
      set_vec = (evt_i & ~COAL_ALL) | rel_all;
      clr_vec = (wr_en_i && (wr_addr_i == ADDR_STAT)) ? wr_data_i[N_SRC-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= '0;
         ctrl_q <= '0;
      end else begin
         stat_q <= (stat_q & ~clr_vec) | set_vec;
         if (wr_en_i && (wr_addr_i == ADDR_MASK)) mask_q <= wr_data_i[N_SRC-1:0];
         if (wr_en_i && (wr_addr_i == ADDR_CTRL)) ctrl_q <= wr_data_i[CTRL_W-1:0];
      end
   end

   always_comb begin
      rd_data_o = '0;
      unique case (reg_addr_e'(rd_addr_i))
         ADDR_STAT: rd_data_o[N_SRC-1:0]  = stat_q;
         ADDR_MASK: rd_data_o[N_SRC-1:0]  = mask_q;
         ADDR_CTRL: rd_data_o[CTRL_W-1:0] = ctrl_q;
         default:   rd_data_o = '0;
      endcase
   end

   assign irq_o = |(stat_q & mask_q);

endmodule

// File: rtl/irq_coal_checker.sv
module irq_coal_checker
   import irq_coal_pkg::*;
#(
   parameter int unsigned N_SRC  = 10,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_SRC-1:0]  evt_i,
   input logic              wr_en_i,
   input logic [1:0]        wr_addr_i,
   input logic [DATA_W-1:0] wr_data_i,
   input logic [N_SRC-1:0]  stat_q,
   input logic [N_SRC-1:0]  mask_q,
   input logic [15:0]       ctrl_q,
   input logic [N_SRC-1:0]  set_vec,
   input logic              irq_o
);

   logic stat_wr;
   assign stat_wr = wr_en_i && (wr_addr_i == ADDR_STAT);

   assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |=> ((stat_q & $past(wr_data_i[N_SRC-1:0] & ~set_vec)) == '0));

   assert_sticky_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_wr |=> ((~stat_q & $past(stat_q)) == '0));

   assert_bypass_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt_i & ~COAL_ALL) != '0) |=>
         ((stat_q & $past(evt_i & ~COAL_ALL)) == $past(evt_i & ~COAL_ALL)));

   assert_masked_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i[9] && mask_q[9] && !(wr_en_i && wr_addr_i == ADDR_MASK)) |=> irq_o);

   assert_immediate_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i[0] && (ctrl_q[6:4] <= 3'd1) && (ctrl_q[3:0] == 4'd0)) |=> stat_q[0]);

endmodule

bind irq_coalesce_unit irq_coal_checker #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_i     (evt_i),
   .wr_en_i   (wr_en_i),
   .wr_addr_i (wr_addr_i),
   .wr_data_i (wr_data_i),
   .stat_q    (stat_q),
   .mask_q    (mask_q),
   .ctrl_q    (ctrl_q),
   .set_vec   (set_vec),
   .irq_o     (irq_o)
);

// File: tb/tb_irq_coalesce_unit.sv
module tb_irq_coalesce_unit;

   localparam int CLK_PERIOD = 10;
   localparam int BASE = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  evt = '0;
   logic        speed100 = 1'b1;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq;

   int nchk = 0;
   int nfail = 0;
   int cyc = 0;
   bit done = 1'b0;
   logic [9:0] tb_mask = '0;

   typedef struct {
      int         at;
      logic [9:0] st;
      logic       irq;
      string      req;
   } exp_t;
   exp_t q[$];

   irq_coalesce_unit #(.N_SRC(10), .BASE_CLKS(BASE), .DATA_W(32)) dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .speed100_i(speed100),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq));

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // Monitor: compares scoreboard items at the falling edge of their cycle
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].at <= cyc) begin
         exp_t e;
         e = q.pop_front();
         nchk++;
         if (rd_data[9:0] !== e.st || irq !== e.irq) begin
            nfail++;
            $display("FAIL %s cyc %0d: status %h irq %b, expected status %h irq %b",
                     e.req, cyc, rd_data[9:0], irq, e.st, e.irq);
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_at(int at, logic [9:0] st, string req);
      exp_t e;
      e.at = at; e.st = st; e.irq = |(st & tb_mask); e.req = req;
      q.push_back(e);
   endtask

   task automatic drain();
      while (q.size() > 0) step();
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic pulse(logic [9:0] b);
      evt = b;
      step();
      evt = '0;
   endtask

   task automatic clear_all();
      wr(2'd0, 32'h3FF);
      expect_at(cyc, 10'h000, "R3");
      drain();
   endtask

   task automatic direct(logic [1:0] a, logic [31:0] exp_v, string req);
      rd_addr = a;
      #1;
      nchk++;
      if (rd_data !== exp_v) begin
         nfail++;
         $display("FAIL %s read addr %0d: got %h, expected %h", req, a, rd_data, exp_v);
      end
      rd_addr = 2'd0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      direct(2'd0, 32'h0, "R1");
      direct(2'd1, 32'h0, "R1");
      direct(2'd2, 32'h0, "R1");
      nchk++;
      if (irq !== 1'b0) begin
         nfail++;
         $display("FAIL R1 irq after reset: got %b, expected 0", irq);
      end

      // R2: register map readback
      wr(2'd1, 32'hFFFF_FFFF);
      tb_mask = 10'h3FF;
      direct(2'd1, 32'h0000_03FF, "R2");
      wr(2'd2, 32'hABCD_5A3C);
      direct(2'd2, 32'h0000_5A3C, "R2");
      direct(2'd3, 32'h0, "R2");
      wr(2'd2, 32'h0);

      // R6: threshold 0, timeout 0 -> immediate
      pulse(10'h001);
      expect_at(cyc, 10'h001, "R6");
      drain();
      wr(2'd0, 32'h001);
      expect_at(cyc, 10'h000, "R3");
      drain();

      // R3: partial clear
      pulse(10'h202);
      expect_at(cyc, 10'h202, "R4");
      drain();
      wr(2'd0, 32'h002);
      expect_at(cyc, 10'h200, "R3");
      drain();
      clear_all();

      // R3: set wins over same-cycle clear
      evt = 10'h200; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h200;
      step();
      evt = '0; wr_en = 1'b0;
      expect_at(cyc, 10'h200, "R3");
      drain();
      clear_all();

      // R4: bypass bits ignore heavy coalescing settings
      wr(2'd2, 32'h7F7F);
      pulse(10'h3AA);
      expect_at(cyc, 10'h3AA, "R4");
      drain();
      clear_all();

      // R7: count threshold 3 on receive lane
      wr(2'd2, 32'h0030);
      pulse(10'h001); expect_at(cyc, 10'h000, "R7");
      pulse(10'h040); expect_at(cyc, 10'h000, "R7");
      pulse(10'h001); expect_at(cyc, 10'h041, "R7");
      drain();
      clear_all();
      pulse(10'h001); expect_at(cyc, 10'h000, "R7");
      pulse(10'h041); expect_at(cyc, 10'h000, "R7");
      pulse(10'h001); expect_at(cyc, 10'h041, "R7");
      drain();
      clear_all();

      // R8: timeout 2 normal cycles at 100 Mbps, second event does not restart
      begin
         int c;
         wr(2'd2, 32'h0072);
         speed100 = 1'b1;
         pulse(10'h001);
         c = cyc;
         expect_at(c, 10'h000, "R8");
         step();
         pulse(10'h040);
         expect_at(c + 3, 10'h000, "R8");
         expect_at(c + 4, 10'h041, "R8");
         drain();
         clear_all();
      end

      // R9: the four cycle lengths with timeout 1
      for (int k = 0; k < 4; k++) begin
         int c;
         int len;
         speed100 = (k == 0 || k == 2);
         len = (k == 0) ? BASE : (k == 1) ? BASE * 10 : (k == 2) ? BASE * 16 : BASE * 160;
         wr(2'd2, (k >= 2) ? 32'h00F1 : 32'h0071);
         pulse(10'h001);
         c = cyc;
         expect_at(c + len - 1, 10'h000, "R9");
         expect_at(c + len, 10'h001, "R9");
         drain();
         clear_all();
      end
      speed100 = 1'b1;

      // R10: transmit lane threshold 2, receive lane immediate
      wr(2'd2, 32'h2000);
      pulse(10'h010); expect_at(cyc, 10'h000, "R10");
      pulse(10'h001); expect_at(cyc, 10'h001, "R10");
      pulse(10'h004); expect_at(cyc, 10'h015, "R10");
      drain();
      clear_all();

      // R5: mask gates the interrupt, not the status
      wr(2'd1, 32'h001);
      tb_mask = 10'h001;
      pulse(10'h200); expect_at(cyc, 10'h200, "R5");
      pulse(10'h001); expect_at(cyc, 10'h201, "R5");
      drain();
      wr(2'd1, 32'h000);
      tb_mask = 10'h000;
      expect_at(cyc, 10'h201, "R5");
      drain();

      step();
      finish_run();
   end

endmodule